// File: doc/BRIEF.md
# ISDN Terminal-Side Layer-1 Activation Controller

This block sequences the layer-1 bring-up and tear-down of a terminal on an ISDN S/T interface. It walks the eight terminal activation states, F1 to F8, from decoded line indications: INFO 0, INFO 2 and INFO 4 seen on the receive side, and loss of framing. It also uses a power-good flag and an activation request from layer 2. From the current state it picks the INFO signal that the transmitter must send. It reports full activation as a level and each deactivation as a single-cycle pulse.

A supervision timer (T3) bounds how long an attempt to activate may last. The timer counts a programmable number of clock cycles. Software can also declare it expired with a one-cycle strobe. Two option inputs change how an expiry is handled once the link has synchronised or has lost framing. The options act only while the terminal-mode input is high. Both option inputs are sampled into registers that clear on reset, so a new option setting takes effect one cycle later.

Top module: `te_act_ctrl`

## Requirements
- R1: During synchronous reset the state goes to F3 (code 3) if power is good and to F1 (code 1) if it is not. After reset the transmit code is INFO 0 (code 0), activated is low and the deactivation pulse is low. The state code is always between 1 and 8.
- R2: Loss of power in any state moves the machine to F1 on the next cycle. From F1 with power good it goes to F2, and from F2 it goes to F3 on the following cycle.
- R3: In F3, a received INFO 2 or INFO 4 moves the machine to F5. With neither present, an activation request moves it to F4. In F4 the transmit code is INFO 1 (code 1).
- R4: F4 goes to F5 on INFO 2 or INFO 4. F5 goes to F7 on INFO 4 and to F6 on INFO 2. F6 goes to F7 on INFO 4. F7 is entered only from F5, F6 or F8. The transmit code is INFO 3 (code 3) in F6 and F7, and activated is high only in F7.
- R5: In F7, loss of framing moves the machine to F8, where the transmit code is INFO 0. In F8, INFO 4 returns the machine to F7 and INFO 2 moves it to F6.
- R6: INFO 0 received in F6 or F7 returns the machine to F3. The deactivation output pulses for exactly one cycle, together with the state change, whenever F3 is entered from any of F4 to F8, and never at any other time.
- R7: T3 starts when the machine leaves F3 toward activation. It keeps counting through F4, F5 and F6, and it is cleared in F7, F3, F2 and F1. It restarts from zero on entry to F8. The expiry output pulses for one cycle, T3_CYCLES-1 cycles after the state leaves F3 (or enters F8). On the cycle after the pulse, an expiry in F4 or F5 returns the machine to F3. The software strobe has the same effect as a timer expiry.
- R8: With the options at their default, an expiry in F6 moves the machine to F3.
- R9: With terminal mode and the F6-disable option set, an expiry in F6 is ignored. The machine stays in F6 and moves to F7 once INFO 4 arrives.
- R10: With the F8-enable option clear, a timer expiry or a software strobe in F8 leaves the machine in F8.
- R11: With terminal mode and the F8-enable option set, a timer expiry or a software strobe in F8 moves the machine to F3.
- R12: With terminal mode low, both options are ignored and the default handling of R8 and R10 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| te_mode_i | input | 1 | Terminal mode; enables both options |
| opt_t3_f8_en_i | input | 1 | Option: T3 expiry acts in F8 |
| opt_t3_f6_dis_i | input | 1 | Option: T3 expiry ignored in F6 |
| pwr_ok_i | input | 1 | Power present |
| act_req_i | input | 1 | Layer-2 activation request |
| rx_info0_i | input | 1 | INFO 0 received |
| rx_info2_i | input | 1 | INFO 2 received |
| rx_info4_i | input | 1 | INFO 4 received |
| rx_lof_i | input | 1 | Loss of framing |
| sw_t3_exp_i | input | 1 | Software T3-expired strobe |
| state_o | output | 4 | Current state, F1=1 to F8=8 |
| tx_info_o | output | 2 | INFO to send: 0=INFO 0, 1=INFO 1, 3=INFO 3 |
| activated_o | output | 1 | High in F7 |
| deactivated_o | output | 1 | One-cycle pulse on entry to F3 from F4 to F8 |
| t3_exp_o | output | 1 | One-cycle T3 expiry pulse |

## Verification
The assertions check the following on every cycle:
- the state code stays legal;
- power loss forces F1;
- the deactivation and expiry outputs are single-cycle pulses;
- F7 is entered only from F5, F6 or F8;
- the option-controlled handling of an expiry in F6 and F8 is followed.

Only the bench's scenarios can show the following:
- the exact timer length, measured from the moment the machine leaves F3;
- the activation sequences and the INFO codes sent along them;
- the transmit codes in each state;
- that terminal mode low cancels both options.

// File: rtl/te_act_pkg.sv
package te_act_pkg;

  typedef enum logic [3:0] {
    ST_F1 = 4'd1,
    ST_F2 = 4'd2,
    ST_F3 = 4'd3,
    ST_F4 = 4'd4,
    ST_F5 = 4'd5,
    ST_F6 = 4'd6,
    ST_F7 = 4'd7,
    ST_F8 = 4'd8
  } act_state_e;

  typedef enum logic [1:0] {
    TX_INFO0 = 2'd0,
    TX_INFO1 = 2'd1,
    TX_INFO3 = 2'd3
  } tx_code_e;

  typedef struct packed {
    logic info0;
    logic info2;
    logic info4;
    logic lof;
  } line_ind_t;

  // INFO signal sent for each state
  function automatic tx_code_e tx_for_state(act_state_e s);
    case (s)
      ST_F4:        return TX_INFO1;
      ST_F6, ST_F7: return TX_INFO3;
      default:      return TX_INFO0;
    endcase
  endfunction

  // states in which the supervision timer counts
  function automatic logic t3_window(act_state_e s);
    return (s == ST_F4) || (s == ST_F5) || (s == ST_F6) || (s == ST_F8);
  endfunction

  // states from which entry to F3 is a deactivation
  function automatic logic past_f3(act_state_e s);
    return (s == ST_F4) || (s == ST_F5) || (s == ST_F6) ||
           (s == ST_F7) || (s == ST_F8);
  endfunction

  // width of a counter that reaches n-1
  function automatic int unsigned cnt_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/te_t3_timer.sv
module te_t3_timer #(
  parameter int unsigned CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  output logic expire
);
  localparam int unsigned CW = te_act_pkg::cnt_width(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          counting;

  assign counting = run_en && !done_q;
  assign expire   = counting && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run_en) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (counting) begin
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/te_opt_gate.sv
module te_opt_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic te_mode,
  input  logic f8_en,
  input  logic f6_dis,
  output logic f8_allow,
  output logic f6_block
);
  logic f8_q, f6_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f8_q <= 1'b0;
      f6_q <= 1'b0;
    end else begin
      f8_q <= f8_en;
      f6_q <= f6_dis;
    end
  end

  assign f8_allow = te_mode && f8_q;
  assign f6_block = te_mode && f6_q;
endmodule

// File: rtl/te_act_fsm.sv
module te_act_fsm
  import te_act_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_ok,
  input  logic       act_req,
  input  line_ind_t  line,
  input  logic       t3_fire,
  input  logic       f6_block,
  input  logic       f8_allow,
  output act_state_e state,
  output logic       deact
);
  act_state_e nxt;
  logic       sig_seen;

  assign sig_seen = line.info2 || line.info4;

  always_comb begin
    nxt = state;
    if (!pwr_ok) begin
      nxt = ST_F1;
    end else begin
      case (state)
        ST_F1: nxt = ST_F2;
        ST_F2: nxt = ST_F3;
        ST_F3: begin
          if (sig_seen)     nxt = ST_F5;
          else if (act_req) nxt = ST_F4;
        end
        ST_F4: begin
          if (sig_seen)     nxt = ST_F5;
          else if (t3_fire) nxt = ST_F3;
        end
        ST_F5: begin
          if (line.info4)      nxt = ST_F7;
          else if (line.info2) nxt = ST_F6;
          else if (t3_fire)    nxt = ST_F3;
        end
        ST_F6: begin
          if (line.info0)                nxt = ST_F3;
          else if (line.info4)           nxt = ST_F7;
          else if (t3_fire && !f6_block) nxt = ST_F3;
        end
        ST_F7: begin
          if (line.info0)      nxt = ST_F3;
          else if (line.lof)   nxt = ST_F8;
          else if (line.info2) nxt = ST_F6;
        end
        ST_F8: begin
          if (line.info4)               nxt = ST_F7;
          else if (line.info2)          nxt = ST_F6;
          else if (t3_fire && f8_allow) nxt = ST_F3;
        end
        default: nxt = ST_F1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= pwr_ok ? ST_F3 : ST_F1;
      deact <= 1'b0;
    end else begin
      state <= nxt;
      deact <= (nxt == ST_F3) && past_f3(state);
    end
  end
endmodule

// File: rtl/te_act_ctrl.sv
module te_act_ctrl
  import te_act_pkg::*;
#(
  parameter int unsigned T3_CYCLES = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       te_mode_i,
  input  logic       opt_t3_f8_en_i,
  input  logic       opt_t3_f6_dis_i,
  input  logic       pwr_ok_i,
  input  logic       act_req_i,
  input  logic       rx_info0_i,
  input  logic       rx_info2_i,
  input  logic       rx_info4_i,
  input  logic       rx_lof_i,
  input  logic       sw_t3_exp_i,
  output logic [3:0] state_o,
  output logic [1:0] tx_info_o,
  output logic       activated_o,
  output logic       deactivated_o,
  output logic       t3_exp_o
);
  act_state_e state;
  line_ind_t  line;
  logic       t3_run, t3_hw, t3_fire;
  logic       f8_allow, f6_block;

  assign line = '{info0: rx_info0_i, info2: rx_info2_i,
                  info4: rx_info4_i, lof: rx_lof_i};

  // named events for the checker
  assign t3_run  = t3_window(state);
  assign t3_fire = t3_hw || sw_t3_exp_i;

  te_opt_gate u_opt (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .te_mode  (te_mode_i),
    .f8_en    (opt_t3_f8_en_i),
    .f6_dis   (opt_t3_f6_dis_i),
    .f8_allow (f8_allow),
    .f6_block (f6_block)
  );

  te_t3_timer #(.CYCLES(T3_CYCLES)) u_t3 (
    .clk    (clk_i),
    .rst_n  (rst_ni),
    .run_en (t3_run),
    .expire (t3_hw)
  );

  te_act_fsm u_fsm (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .pwr_ok   (pwr_ok_i),
    .act_req  (act_req_i),
    .line     (line),
    .t3_fire  (t3_fire),
    .f6_block (f6_block),
    .f8_allow (f8_allow),
    .state    (state),
    .deact    (deactivated_o)
  );

  assign state_o     = state;
  assign tx_info_o   = tx_for_state(state);
  assign activated_o = (state == ST_F7);
  assign t3_exp_o    = t3_hw;
endmodule

// File: rtl/te_act_ctrl_chk.sv
module te_act_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_ok,
  input logic       rx_info0,
  input logic       rx_info2,
  input logic       rx_info4,
  input logic       t3_fire,
  input logic       t3_exp,
  input logic       f6_block,
  input logic       f8_allow,
  input logic [3:0] state,
  input logic       deact
);
  assert_legal_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state >= 4'd1) && (state <= 4'd8));

  assert_power_loss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> state == 4'd1);

  assert_f7_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd7) && ($past(state) != 4'd7) |->
      ($past(state) == 4'd5) || ($past(state) == 4'd6) || ($past(state) == 4'd8));

  assert_deact_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    deact |-> (state == 4'd3) && ($past(state) >= 4'd4));

  assert_deact_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    deact |=> !deact);

  assert_t3_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    t3_exp |=> !t3_exp);

  assert_f6_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_ok && (state == 4'd6) && f6_block && t3_fire && !rx_info0 && !rx_info4
      |=> state == 4'd6);

  assert_f8_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_ok && (state == 4'd8) && !f8_allow && !rx_info4 && !rx_info2
      |=> state == 4'd8);

  assert_f8_force_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_ok && (state == 4'd8) && f8_allow && t3_fire && !rx_info4 && !rx_info2
      |=> state == 4'd3);
endmodule

bind te_act_ctrl te_act_ctrl_chk u_chk (
  .clk      (clk_i),
  .rst_n    (rst_ni),
  .pwr_ok   (pwr_ok_i),
  .rx_info0 (rx_info0_i),
  .rx_info2 (rx_info2_i),
  .rx_info4 (rx_info4_i),
  .t3_fire  (t3_fire),
  .t3_exp   (t3_exp_o),
  .f6_block (f6_block),
  .f8_allow (f8_allow),
  .state    (state_o),
  .deact    (deactivated_o)
);

// File: tb/te_act_ctrl_test.sv
module te_act_ctrl_test;
  localparam int T3L = 16;

  logic clk = 1'b0;
  logic rst_n, te_mode, f8_en, f6_dis, pwr_ok, act_req;
  logic info0, info2, info4, lof, sw_exp;
  logic [3:0] state;
  logic [1:0] tx;
  logic act, deact, t3x;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  te_act_ctrl #(.T3_CYCLES(T3L)) uut (
    .clk_i(clk), .rst_ni(rst_n), .te_mode_i(te_mode),
    .opt_t3_f8_en_i(f8_en), .opt_t3_f6_dis_i(f6_dis),
    .pwr_ok_i(pwr_ok), .act_req_i(act_req),
    .rx_info0_i(info0), .rx_info2_i(info2), .rx_info4_i(info4),
    .rx_lof_i(lof), .sw_t3_exp_i(sw_exp),
    .state_o(state), .tx_info_o(tx), .activated_o(act),
    .deactivated_o(deact), .t3_exp_o(t3x)
  );

  task automatic chk(input string what, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, actual, expected);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic quiet();
    act_req = 0; info0 = 0; info2 = 0; info4 = 0; lof = 0; sw_exp = 0;
  endtask

  task automatic reset_to(input logic pwr);
    quiet();
    pwr_ok = pwr; rst_n = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  task automatic set_opts(input logic mode, input logic e8, input logic d6);
    te_mode = mode; f8_en = e8; f6_dis = d6;
    tick(); tick();
  endtask

  task automatic wait_t3(output int n);
    n = 0;
    while (!t3x && n < 4 * T3L) begin
      tick();
      n++;
    end
  endtask

  task automatic reach_f7();
    info4 = 1; tick(); tick(); info4 = 0;
    chk("R4 F7 via F5", state, 7);
  endtask

  task automatic t_reset();
    te_mode = 0; f8_en = 0; f6_dis = 0;
    reset_to(1'b0);
    chk("R1 reset no power state", state, 1);
    chk("R1 reset tx", tx, 0);
    chk("R1 reset activated", act, 0);
    chk("R1 reset deact", deact, 0);
    reset_to(1'b1);
    chk("R1 reset with power state", state, 3);
  endtask

  task automatic t_power();
    reset_to(1'b1);
    pwr_ok = 0; tick();
    chk("R2 power loss", state, 1);
    pwr_ok = 1; tick();
    chk("R2 F1 to F2", state, 2);
    tick();
    chk("R2 F2 to F3", state, 3);
    chk("R6 no deact from F2", deact, 0);
    reach_f7();
    pwr_ok = 0; tick();
    chk("R2 power loss in F7", state, 1);
    pwr_ok = 1;
  endtask

  task automatic t_activate();
    reset_to(1'b1);
    act_req = 1; tick(); act_req = 0;
    chk("R3 request to F4", state, 4);
    chk("R3 INFO1 in F4", tx, 1);
    info2 = 1; tick();
    chk("R4 F4 to F5", state, 5);
    chk("R4 INFO0 in F5", tx, 0);
    tick(); info2 = 0;
    chk("R4 F5 to F6", state, 6);
    chk("R4 INFO3 in F6", tx, 3);
    chk("R4 not active in F6", act, 0);
    info4 = 1; tick(); info4 = 0;
    chk("R4 F6 to F7", state, 7);
    chk("R4 activated", act, 1);
    chk("R4 INFO3 in F7", tx, 3);
    reset_to(1'b1);
    info2 = 1; act_req = 1; tick(); quiet();
    chk("R3 signal beats request", state, 5);
  endtask

  task automatic t_lof();
    reset_to(1'b1);
    reach_f7();
    lof = 1; tick(); lof = 0;
    chk("R5 F7 to F8", state, 8);
    chk("R5 INFO0 in F8", tx, 0);
    chk("R5 not active in F8", act, 0);
    info4 = 1; tick(); info4 = 0;
    chk("R5 F8 to F7", state, 7);
    lof = 1; tick(); lof = 0;
    info2 = 1; tick(); info2 = 0;
    chk("R5 F8 to F6", state, 6);
  endtask

  task automatic t_deact();
    reset_to(1'b1);
    info2 = 1; tick(); tick(); info2 = 0;
    info0 = 1; tick(); info0 = 0;
    chk("R6 F6 INFO0 to F3", state, 3);
    chk("R6 deact pulse", deact, 1);
    tick();
    chk("R6 deact one cycle", deact, 0);
    reach_f7();
    info0 = 1; tick(); info0 = 0;
    chk("R6 F7 INFO0 to F3", state, 3);
    chk("R6 deact from F7", deact, 1);
  endtask

  task automatic t_t3_f4();
    int n;
    reset_to(1'b1);
    act_req = 1; tick(); act_req = 0;
    chk("R7 no expiry on entry", t3x, 0);
    wait_t3(n);
    chk("R7 timer length F4", n, T3L - 1);
    chk("R7 still F4 at expiry", state, 4);
    tick();
    chk("R7 expiry F4 to F3", state, 3);
    chk("R7 expiry pulse ends", t3x, 0);
    chk("R6 deact after T3", deact, 1);
    act_req = 1; tick(); act_req = 0;
    sw_exp = 1; tick(); sw_exp = 0;
    chk("R7 software strobe F4", state, 3);
  endtask

  task automatic t_f6(input logic mode, input logic d6, input string tag);
    int n;
    reset_to(1'b1);
    set_opts(mode, 1'b0, d6);
    info2 = 1; tick();
    n = 0; tick(); n++; info2 = 0;
    chk({tag, " reached F6"}, state, 6);
    while (!t3x && n < 4 * T3L) begin tick(); n++; end
    chk({tag, " timer length"}, n, T3L - 1);
    tick();
    if (mode && d6) begin
      chk({tag, " stays F6"}, state, 6);
      tick(); tick();
      chk({tag, " still F6"}, state, 6);
      info4 = 1; tick(); info4 = 0;
      chk({tag, " INFO4 to F7"}, state, 7);
    end else begin
      chk({tag, " expiry to F3"}, state, 3);
    end
  endtask

  task automatic t_f8(input logic mode, input logic e8, input string tag);
    int n;
    reset_to(1'b1);
    set_opts(mode, e8, 1'b0);
    reach_f7();
    lof = 1; tick(); lof = 0;
    wait_t3(n);
    chk({tag, " timer length F8"}, n, T3L - 1);
    tick();
    chk({tag, " after timer expiry"}, state, (mode && e8) ? 3 : 8);
    if (state == 4'd3) begin
      reach_f7();
      lof = 1; tick(); lof = 0;
    end
    sw_exp = 1; tick(); sw_exp = 0;
    chk({tag, " after strobe"}, state, (mode && e8) ? 3 : 8);
  endtask

  initial begin
    quiet();
    te_mode = 0; f8_en = 0; f6_dis = 0; pwr_ok = 0; rst_n = 0;
    t_reset();
    t_power();
    t_activate();
    t_lof();
    t_deact();
    t_t3_f4();
    t_f6(1'b0, 1'b0, "R8 default F6");
    t_f6(1'b1, 1'b1, "R9 F6 disabled");
    t_f8(1'b1, 1'b0, "R10 default F8");
    t_f8(1'b1, 1'b1, "R11 F8 enabled");
    t_f6(1'b0, 1'b1, "R12 mode off F6");
    t_f8(1'b0, 1'b1, "R12 mode off F8");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule